// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is the target side of a 32-bit bus on which address and data share the same lines. Each transaction opens with one address phase. In that phase the four command/byte-enable lines carry a command code and the shared lines carry an address. One or more data phases follow on the same pins, and in those phases the command lines act as active-low byte enables. The block decodes the command and checks the address against its own I/O window, its own memory window, and its configuration space (selected by a dedicated select input). If the address hits one of them, the block claims the cycle and moves data between the bus and a simple local register port.

Both sides pace each data phase. The master holds its ready low to move a word. The target's ready follows a local ready input, so the register side can insert wait states. During a burst the local address steps by four bytes per completed word. When a burst is about to leave the decoded window, the target signals stop together with its last ready. The block also generates even parity for the words it drives. Every bus control line is active-low. The shared data lines are split into separate in, out and enable signals.

Top module: `mbus_target`

## Requirements
- R1: While reset is asserted, devsel_n, trdy_n and stop_n are high, tgt_oe, ad_oe, par_oe, loc_wr and loc_rd are low.
- R2: An address phase is the first clock with frame_n low after a clock with frame_n high. A claimed cycle drives devsel_n (and tgt_oe) active in the clock that follows that phase. Command codes on cbe_n are 0010/0011 I/O read/write, 0110/0111 memory read/write, 1100 multiple memory read, 1110 memory read line, 1111 memory write and invalidate, and 1010/1011 configuration read/write. Bit 0 of the code is 1 for writes. The block never claims any other code, including 0100, 0101, 1000 and 1001.
- R3: An I/O command is claimed when the full byte address lies in [IO_BASE, IO_BASE+IO_SIZE). loc_addr then carries that byte address including bits 1:0, and loc_space is 1.
- R4: A memory command is claimed when the address with bits 1:0 cleared lies in [MEM_BASE, MEM_BASE+MEM_SIZE). loc_addr has bits 1:0 zero, and loc_space is 2.
- R5: A configuration command is claimed only with idsel high, address bits 1:0 = 00 and function bits 10:8 = 000. loc_addr is the register index (address bits 7:2) times four, and loc_space is 3.
- R6: A word moves only at an edge where irdy_n and trdy_n are both low. During a data phase, trdy_n is low exactly when loc_rdy is high. On such an edge, a write pulses loc_wr with loc_wdata = ad_in and loc_be = ~cbe_n. A read pulses loc_rd. While a read data phase is open, ad_oe is high and ad_out equals loc_rdata.
- R7: After each completed non-final, non-stopped data phase, loc_addr increases by 4.
- R8: If frame_n is high when a word moves, devsel_n, trdy_n and stop_n are all high from the next clock.
- R9: When the next dword would fall outside the decoded window (256 bytes for configuration), stop_n is low together with trdy_n. After that word, trdy_n stays high while stop_n and devsel_n stay low until frame_n is high, and everything is released in the clock after that.
- R10: par_out equals the XOR of ad_out and cbe_n from the previous clock. par_oe equals the previous clock's ad_oe.
- R11: An address phase that matches no window leaves devsel_n high for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_in | input | 32 | Shared address/data lines, as seen by the target |
| ad_out | output | 32 | Read data the target drives onto the shared lines |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_n | input | 4 | Command in address phase, active-low byte enables in data phases |
| frame_n | input | 1 | Master's transaction framing, low until the final data phase |
| irdy_n | input | 1 | Master ready |
| idsel | input | 1 | Configuration select, active high |
| trdy_n | output | 1 | Target ready |
| devsel_n | output | 1 | Target claims the cycle |
| stop_n | output | 1 | Target asks the master to end the burst |
| tgt_oe | output | 1 | Drive enable for trdy_n, devsel_n and stop_n |
| par_out | output | 1 | Even parity for the word driven in the previous clock |
| par_oe | output | 1 | Drive enable for par_out |
| loc_addr | output | 32 | Local register address |
| loc_space | output | 2 | Space of the access: 1 I/O, 2 memory, 3 configuration |
| loc_wr | output | 1 | Local write strobe, one per moved word |
| loc_rd | output | 1 | Local read strobe, one per moved word |
| loc_wdata | output | 32 | Local write data |
| loc_be | output | 4 | Local byte strobes, active high |
| loc_rdata | input | 32 | Local read data for loc_addr, combinational |
| loc_rdy | input | 1 | Local side ready to complete the current phase |

## Verification
The assertions rely on the master following the bus rules. frame_n rises only in a clock where irdy_n is low. After a stop, the master raises frame_n and does not reassert it until the claimed transaction has been released. loc_rdata is a pure function of loc_addr. The bench master keeps to these rules: it holds frame_n low through its own wait states and raises it only together with irdy_n on the final phase. It ends an aborted or stopped burst with one frame_n-high phase before going idle. Its register side returns data computed from the address alone.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_IO   = 2'd1,
        SP_MEM  = 2'd2,
        SP_CFG  = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e      phase;
        space_e      space;
        logic        wr;
        logic [31:0] addr;
        logic [32:0] lim;
        logic        frame_prev;
    } ctl_t;

    typedef struct packed {
        logic par;
        logic oe;
    } par_t;

endpackage

// File: rtl/mbt_decode.sv
module mbt_decode
    import mbt_pkg::*;
#(
    parameter logic [31:0] IO_BASE    = 32'h0000_1000,
    parameter logic [31:0] IO_SIZE    = 32'h0000_0040,
    parameter logic [31:0] MEM_BASE   = 32'h4000_0000,
    parameter logic [31:0] MEM_SIZE   = 32'h0000_0100,
    parameter int          CFG_DWORDS = 64
) (
    input  logic [31:0] ad,
    input  logic [3:0]  cmd,
    input  logic        idsel,
    output space_e      space,
    output logic [31:0] base_addr,
    output logic [32:0] limit,
    output logic        wr
);
    localparam logic [32:0] IO_LO  = {1'b0, IO_BASE};
    localparam logic [32:0] IO_HI  = IO_LO + {1'b0, IO_SIZE};
    localparam logic [32:0] MEM_LO = {1'b0, MEM_BASE};
    localparam logic [32:0] MEM_HI = MEM_LO + {1'b0, MEM_SIZE};
    localparam logic [32:0] CFG_HI = 33'(CFG_DWORDS * 4);

    logic [32:0] byte_a;
    logic [32:0] dword_a;

    always_comb begin
        byte_a    = {1'b0, ad};
        dword_a   = {1'b0, ad[31:2], 2'b00};
        space     = SP_NONE;
        base_addr = ad;
        limit     = '0;
        wr        = cmd[0];
        case (cmd)
            4'b0010, 4'b0011: begin
                if (byte_a >= IO_LO && byte_a < IO_HI) begin
                    space = SP_IO;
                    limit = IO_HI;
                end
            end
            4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: begin
                if (dword_a >= MEM_LO && dword_a < MEM_HI) begin
                    space     = SP_MEM;
                    base_addr = dword_a[31:0];
                    limit     = MEM_HI;
                end
            end
            4'b1010, 4'b1011: begin
                if (idsel && ad[1:0] == 2'b00 && ad[10:8] == 3'b000) begin
                    space     = SP_CFG;
                    base_addr = {24'd0, ad[7:2], 2'b00};
                    limit     = CFG_HI;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mbt_par_gen.sv
module mbt_par_gen
    import mbt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data,
    input  logic [CMD_W-1:0]  cbe,
    input  logic              drive,
    output logic              par,
    output logic              par_oe
);
    par_t q, d;

    always_comb begin
        d.par = ^{data, cbe};
        d.oe  = drive;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{par: 1'b0, oe: 1'b0};
        else        q <= d;
    end

    assign par    = q.par;
    assign par_oe = q.oe;
endmodule

// File: rtl/mbus_target.sv
module mbus_target
    import mbt_pkg::*;
#(
    parameter logic [31:0] IO_BASE    = 32'h0000_1000,
    parameter logic [31:0] IO_SIZE    = 32'h0000_0040,
    parameter logic [31:0] MEM_BASE   = 32'h4000_0000,
    parameter logic [31:0] MEM_SIZE   = 32'h0000_0100,
    parameter int          CFG_DWORDS = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    input  logic [3:0]  cbe_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    output logic        trdy_n,
    output logic        devsel_n,
    output logic        stop_n,
    output logic        tgt_oe,
    output logic        par_out,
    output logic        par_oe,
    output logic [31:0] loc_addr,
    output logic [1:0]  loc_space,
    output logic        loc_wr,
    output logic        loc_rd,
    output logic [31:0] loc_wdata,
    output logic [3:0]  loc_be,
    input  logic [31:0] loc_rdata,
    input  logic        loc_rdy
);
    localparam logic [32:0] STEP = 33'd4;

    ctl_t q, d;

    space_e      dec_space;
    logic [31:0] dec_addr;
    logic [32:0] dec_lim;
    logic        dec_wr;

    logic        addr_phase;
    logic        in_data;
    logic        at_end;
    logic        xfer;
    logic [32:0] next_dw;

    mbt_decode #(
        .IO_BASE   (IO_BASE),
        .IO_SIZE   (IO_SIZE),
        .MEM_BASE  (MEM_BASE),
        .MEM_SIZE  (MEM_SIZE),
        .CFG_DWORDS(CFG_DWORDS)
    ) u_dec (
        .ad       (ad_in),
        .cmd      (cbe_n),
        .idsel    (idsel),
        .space    (dec_space),
        .base_addr(dec_addr),
        .limit    (dec_lim),
        .wr       (dec_wr)
    );

    always_comb begin
        addr_phase = (q.phase == PH_IDLE) && q.frame_prev && !frame_n;
        in_data    = (q.phase == PH_DATA);
        next_dw    = {1'b0, q.addr[31:2], 2'b00} + STEP;
        at_end     = next_dw >= q.lim;
        xfer       = in_data && loc_rdy && !irdy_n;

        d            = q;
        d.frame_prev = frame_n;
        case (q.phase)
            PH_IDLE: begin
                if (addr_phase && dec_space != SP_NONE) begin
                    d.phase = PH_DATA;
                    d.space = dec_space;
                    d.wr    = dec_wr;
                    d.addr  = dec_addr;
                    d.lim   = dec_lim;
                end
            end
            PH_DATA: begin
                if (xfer) begin
                    if (frame_n)     d.phase = PH_IDLE;
                    else if (at_end) d.phase = PH_HOLD;
                    else             d.addr  = q.addr + 32'd4;
                end
            end
            PH_HOLD: begin
                if (frame_n) d.phase = PH_IDLE;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{phase: PH_IDLE, space: SP_NONE, wr: 1'b0, addr: '0,
                   lim: '0, frame_prev: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign devsel_n  = (q.phase == PH_IDLE);
    assign tgt_oe    = (q.phase != PH_IDLE);
    assign trdy_n    = !(in_data && loc_rdy);
    assign stop_n    = !((in_data && loc_rdy && at_end) || q.phase == PH_HOLD);
    assign ad_oe     = in_data && !q.wr;
    assign ad_out    = loc_rdata;
    assign loc_addr  = q.addr;
    assign loc_space = q.space;
    assign loc_wr    = xfer && q.wr;
    assign loc_rd    = xfer && !q.wr;
    assign loc_wdata = ad_in;
    assign loc_be    = ~cbe_n;

    mbt_par_gen #(.DATA_W(32), .CMD_W(4)) u_par (
        .clk   (clk),
        .rst_n (rst_n),
        .data  (ad_out),
        .cbe   (cbe_n),
        .drive (ad_oe),
        .par   (par_out),
        .par_oe(par_oe)
    );

    // R2: a claim appears only in the clock after an address phase
    a_r2_claim_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(addr_phase));

    // R2: reserved command codes are never claimed
    a_r2_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_phase && (cbe_n inside {4'b0100, 4'b0101, 4'b1000, 4'b1001})) |=> devsel_n);

    // R6: target ready only inside a claimed cycle
    a_r6_trdy_in_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R6: at most one local strobe per clock
    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_wr, loc_rd}));

    // R7: burst address steps by one dword
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !frame_n && !at_end) |=> (loc_addr == $past(loc_addr) + 32'd4));

    // R8: final phase releases the bus
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && frame_n) |=> (devsel_n && trdy_n && stop_n));

    // R9: after a stop with data, stop and devsel hold while trdy is off
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !stop_n && !frame_n) |=> (!stop_n && !devsel_n && trdy_n));
endmodule

// File: tb/mbus_target_test.sv
`timescale 1ns/1ps
module mbus_target_test;
    localparam logic [31:0] IOB  = 32'h0000_1000;
    localparam logic [31:0] IOS  = 32'h0000_0040;
    localparam logic [31:0] MEMB = 32'h4000_0000;
    localparam logic [31:0] MEMS = 32'h0000_0100;
    localparam logic [31:0] KEY  = 32'h5A5A_3C3C;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0, loc_rdy = 1'b1;
    logic [31:0] ad_out, loc_addr, loc_wdata, loc_rdata;
    logic        ad_oe, trdy_n, devsel_n, stop_n, tgt_oe, par_out, par_oe, loc_wr, loc_rd;
    logic [1:0]  loc_space;
    logic [3:0]  loc_be;

    assign loc_rdata = loc_addr ^ KEY;

    mbus_target uut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .cbe_n(cbe_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .tgt_oe(tgt_oe),
        .par_out(par_out), .par_oe(par_oe), .loc_addr(loc_addr), .loc_space(loc_space),
        .loc_wr(loc_wr), .loc_rd(loc_rd), .loc_wdata(loc_wdata), .loc_be(loc_be),
        .loc_rdata(loc_rdata), .loc_rdy(loc_rdy)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // reference model state
    bit          m_act = 0, m_hold = 0, m_wr = 0, m_fprev = 1, p_par = 0, p_oe = 0;
    logic [31:0] m_addr = '0;
    logic [32:0] m_lim = '0;
    logic [1:0]  m_space = 2'd0;
    bit          e_dat, e_end, e_xfer, e_oe, e_trdy_n, e_stop_n;

    function automatic bit ref_claim(input logic [3:0] c, input logic [31:0] a, input bit ids,
                                     output logic [31:0] na, output logic [32:0] lim,
                                     output logic [1:0] sp);
        longint unsigned av = a;
        longint unsigned dv = {a[31:2], 2'b00};
        na = a; lim = '0; sp = 2'd0;
        if (c == 4'd2 || c == 4'd3) begin
            if (av >= IOB && av < longint'(IOB) + IOS) begin
                lim = 33'(longint'(IOB) + IOS); sp = 2'd1; return 1;
            end
        end else if (c == 4'd6 || c == 4'd7 || c == 4'd12 || c == 4'd14 || c == 4'd15) begin
            if (dv >= MEMB && dv < longint'(MEMB) + MEMS) begin
                na = 32'(dv); lim = 33'(longint'(MEMB) + MEMS); sp = 2'd2; return 1;
            end
        end else if (c == 4'd10 || c == 4'd11) begin
            if (ids && a[1:0] == 2'b00 && a[10:8] == 3'b000) begin
                na = {24'd0, a[7:2], 2'b00}; lim = 33'd256; sp = 2'd3; return 1;
            end
        end
        return 0;
    endfunction

    task automatic calc();
        longint unsigned nxt = longint'({m_addr[31:2], 2'b00}) + 4;
        e_dat    = m_act && !m_hold;
        e_end    = nxt >= longint'(m_lim);
        e_trdy_n = !(e_dat && loc_rdy);
        e_stop_n = !((e_dat && loc_rdy && e_end) || m_hold);
        e_xfer   = e_dat && loc_rdy && !irdy_n;
        e_oe     = e_dat && !m_wr;
    endtask

    always @(negedge clk) begin
        logic [31:0] na; logic [32:0] lim; logic [1:0] sp;
        string t_dev, t_hs, t_stop, t_par, t_adr;
        calc();
        if (!rst_n) begin
            m_act = 0; m_hold = 0; m_fprev = 1; p_oe = 0; p_par = 0; m_addr = '0; m_lim = '0;
        end else begin
            p_par = ^{(m_addr ^ KEY), cbe_n};
            p_oe  = e_oe;
            if (!m_act) begin
                if (m_fprev && !frame_n && ref_claim(cbe_n, ad_in, idsel, na, lim, sp)) begin
                    m_act = 1; m_hold = 0; m_addr = na; m_lim = lim; m_wr = cbe_n[0]; m_space = sp;
                end
            end else if (m_hold) begin
                if (frame_n) begin m_act = 0; m_hold = 0; end
            end else if (e_xfer) begin
                if (frame_n)    m_act = 0;
                else if (e_end) m_hold = 1;
                else            m_addr = m_addr + 32'd4;
            end
            m_fprev = frame_n;
        end
        calc();
        t_dev  = rst_n ? "R2 R8 R11 devsel_n" : "R1 devsel_n";
        t_hs   = rst_n ? "R6 handshake" : "R1 handshake";
        t_stop = rst_n ? "R9 stop_n" : "R1 stop_n";
        t_par  = rst_n ? "R10 parity" : "R1 parity";
        t_adr  = "R3 R4 R5 R7 loc_addr";
        chk(devsel_n == !m_act, t_dev, 32'(devsel_n), 32'(!m_act));
        chk(tgt_oe == m_act, t_dev, 32'(tgt_oe), 32'(m_act));
        chk(trdy_n == e_trdy_n, t_hs, 32'(trdy_n), 32'(e_trdy_n));
        chk(stop_n == e_stop_n, t_stop, 32'(stop_n), 32'(e_stop_n));
        chk(ad_oe == e_oe, t_hs, 32'(ad_oe), 32'(e_oe));
        chk(loc_wr == (e_xfer && m_wr), t_hs, 32'(loc_wr), 32'(e_xfer && m_wr));
        chk(loc_rd == (e_xfer && !m_wr), t_hs, 32'(loc_rd), 32'(e_xfer && !m_wr));
        chk(par_oe == p_oe, t_par, 32'(par_oe), 32'(p_oe));
        if (p_oe) chk(par_out == p_par, t_par, 32'(par_out), 32'(p_par));
        if (e_oe) chk(ad_out == (m_addr ^ KEY), "R6 read data", ad_out, m_addr ^ KEY);
        if (e_xfer) begin
            chk(loc_addr == m_addr, t_adr, loc_addr, m_addr);
            chk(loc_space == m_space, "R3 R4 R5 loc_space", 32'(loc_space), 32'(m_space));
            if (m_wr) begin
                chk(loc_wdata == ad_in, "R6 write data", loc_wdata, ad_in);
                chk(loc_be == ~cbe_n, "R6 byte strobes", 32'(loc_be), 32'(~cbe_n));
            end
        end
    end

    // local ready pattern
    bit rdy_mode = 0;
    int cyc = 0;
    always @(negedge clk) begin
        #1;
        cyc++;
        loc_rdy = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk); #1;
            frame_n = 1; irdy_n = 1; cbe_n = 4'hF; ad_in = '0; idsel = 0;
        end
    endtask

    task automatic txn(input logic [3:0] cmd, input logic [31:0] a, input bit ids,
                       input int nph, input int iw);
        bit stopped = 0;
        bit frame_up = 0;
        @(negedge clk); #1;
        frame_n = 0; irdy_n = 1; ad_in = a; cbe_n = cmd; idsel = ids;
        for (int i = 0; i < nph && !stopped; i++) begin
            bit last = (i == nph - 1);
            bit done = 0;
            int guard = 0;
            if (iw > 0 && i == 1) begin
                repeat (iw) begin
                    @(negedge clk); #1;
                    irdy_n = 1; ad_in = 32'hDEAD_0000;
                end
            end
            while (!done) begin
                @(negedge clk); #1;
                frame_n = last; irdy_n = 0; idsel = 0;
                ad_in = a ^ (32'h0101_0101 * (i + 1));
                cbe_n = (i % 2 == 0) ? 4'b0000 : 4'b1010;
                frame_up = last;
                #4;
                if (!trdy_n) done = 1;
                if (!stop_n) stopped = 1;
                guard++;
                if (guard > 4 && devsel_n) begin done = 1; stopped = 1; end
            end
        end
        if (stopped && !frame_up) begin
            @(negedge clk); #1;
            frame_n = 1; irdy_n = 0;
        end
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        idle(2);
        txn(4'b0011, IOB + 32'd1, 0, 1, 0);          // R3 I/O write, byte address
        txn(4'b0010, IOB + 32'h10, 0, 3, 2);         // R3 R6 R7 I/O read burst, master waits
        rdy_mode = 1;
        txn(4'b0111, MEMB + 32'h22, 0, 4, 0);        // R4 R7 memory write, target waits
        txn(4'b0110, MEMB + MEMS - 32'd8, 0, 4, 0);  // R9 memory read stopped at window end
        rdy_mode = 0;
        txn(4'b1010, 32'h0000_00F8, 1, 3, 0);        // R5 R9 config read stopped at index 63
        txn(4'b1011, 32'h0000_0010, 1, 2, 1);        // R5 config write
        txn(4'b1010, 32'h0000_0010, 0, 1, 0);        // R11 idsel low
        txn(4'b1010, 32'h0000_0011, 1, 1, 0);        // R11 low bits not zero
        txn(4'b1010, 32'h0000_0110, 1, 1, 0);        // R11 function 1
        txn(4'b0100, MEMB, 0, 1, 0);                 // R2 reserved codes
        txn(4'b0101, MEMB, 0, 1, 0);
        txn(4'b1000, MEMB, 0, 1, 0);
        txn(4'b1001, MEMB, 0, 1, 0);
        txn(4'b0000, MEMB, 0, 1, 0);                 // R2 other unclaimed codes
        txn(4'b0001, MEMB, 0, 1, 0);
        txn(4'b1101, MEMB, 0, 1, 0);
        txn(4'b0110, MEMB + MEMS, 0, 1, 0);          // R11 memory out of range
        txn(4'b0011, IOB - 32'd1, 0, 1, 0);          // R11 I/O out of range
        txn(4'b1100, MEMB + 32'h40, 0, 2, 0);        // R2 multiple memory read
        txn(4'b1110, MEMB + 32'h80, 0, 3, 1);        // R2 memory read line
        rdy_mode = 1;
        txn(4'b1111, MEMB + 32'hF4, 0, 3, 0);        // R2 R9 write and invalidate at end
        rdy_mode = 0;
        idle(3);
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog expired: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule